// File: doc/BRIEF.md
# Match Priority Cascade for Shared CAM Result Bus

This block is the arbitration slice placed beside each content-addressable memory device when several devices share one result bus. The CAM array is outside it: each slice receives its device's local match indication, local match address and local multiple-match indication, and keeps them as the device's match state when a compare cycle selects the device. A device that sits out a compare drops any earlier match, so stale hits never reach the bus.

The slices form a daisy chain. A device passes a "someone above has a hit" signal down the chain whenever it has a hit itself or one arrives from above. Only the first matching device in the chain may drive the result bus, and only while its output enable is low. The result word is the device's page address above its match address. When no device holds a match, the slice configured as the last in the chain drives all ones. The bus is modelled as a data word plus a drive-enable per device, so the system level resolves it as a wired bus.

A device is picked for a compare by either of two active-low chip selects, or by an internal device-select register whose page field equals the device's own page address while its enable bit is low.

Top module: `cam_prio_cascade`

## Requirements
- R1: A compare selects the device when `cs_a_n` or `cs_b_n` (or both) is low at the sampling clock edge.
- R2: The select register is written from `dsel_wdata` when `dsel_we` is high; bit PAGE_W is an active-low enable and bits PAGE_W-1:0 a page value. With both chip selects high, a compare selects the device only if the register's enable bit is 0 and its page value equals `page_addr`; the value in the register before that edge's write is the one used.
- R3: At a clock edge with `cmp_go` high, a selected device takes `loc_hit` into `match_out`, `loc_hit` AND `loc_multi` into `multi_out`, and keeps `loc_addr`; an unselected device sets both `match_out` and `multi_out` to 0.
- R4: At a clock edge with `cmp_go` low, `match_out` and `multi_out` hold their values.
- R5: `prio_out` is high whenever `prio_in` is high or `match_out` is high, and low otherwise.
- R6: `res_oe` is high with `res_data` equal to {`page_addr`, kept match address} exactly when `oe_n` is low, `prio_in` is low and `match_out` is high.
- R7: With `prio_in` high the device never drives (`res_oe` low), whatever `oe_n`; with `oe_n` high it never drives.
- R8: With `last_dev` high, `oe_n` low, `prio_in` low and `match_out` low, the device drives `res_data` as all ones; a device with `last_dev` low never drives without a match.
- R9: After reset `match_out` and `multi_out` are 0 and the select register holds enable bit 1 (disabled).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_addr | input | PAGE_W | This device's page address |
| last_dev | input | 1 | High on the device at the bottom of the chain |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| dsel_we | input | 1 | Write strobe for the select register |
| dsel_wdata | input | PAGE_W+1 | Select register write value: {enable_n, page} |
| cmp_go | input | 1 | Compare cycle strobe |
| loc_hit | input | 1 | Local match from the CAM array |
| loc_addr | input | ADDR_W | Local match address from the CAM array |
| loc_multi | input | 1 | Local multiple-match from the CAM array |
| prio_in | input | 1 | Chain input: a higher device holds a match |
| oe_n | input | 1 | Output enable, active low |
| prio_out | output | 1 | Chain output to the next lower device |
| match_out | output | 1 | Held match state |
| multi_out | output | 1 | Held multiple-match state |
| res_data | output | PAGE_W+ADDR_W | Result word, valid while res_oe is high |
| res_oe | output | 1 | Result bus drive enable |

## Verification
A wrong held match state shows up one clock after the compare edge, both on `match_out` and on the chain output, and on the resolved bus as the wrong owner, a lost owner or two devices driving at once. A fault in select decoding appears the same way, since the device then keeps or drops a hit it should not. A fault in the bus gate needs no clock at all: it shows as soon as `oe_n` or `prio_in` changes, by a driver count other than the expected zero or one, or by a wrong word.

// File: rtl/cam_cascade_pkg.sv
package cam_cascade_pkg;

   // What a slice puts on the shared result bus
   typedef enum logic [1:0] {
      DRV_OFF  = 2'd0,
      DRV_HIT  = 2'd1,
      DRV_ONES = 2'd2
   } drv_mode_e;

endpackage

// File: rtl/cam_dev_select.sv
module cam_dev_select #(
   parameter int PAGE_W       = 4,
   parameter bit USE_DSEL_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] page_addr,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              dsel_we,
   input  logic [PAGE_W:0]   dsel_wdata,
   output logic              dev_sel,
   output logic [PAGE_W:0]   dsel_q
);

   localparam int EN_BIT = PAGE_W;

   logic pin_sel;
   logic reg_sel;

   assign pin_sel = ~cs_a_n | ~cs_b_n;

   generate
      if (USE_DSEL_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dsel_q <= {1'b1, {PAGE_W{1'b0}}};
            end else if (dsel_we) begin
               dsel_q <= dsel_wdata;
            end
         end
         assign reg_sel = ~dsel_q[EN_BIT] & (dsel_q[PAGE_W-1:0] == page_addr);
      end else begin : g_pins_only
         logic unused_sel_inputs;
         assign unused_sel_inputs = ^{clk, rst_n, dsel_we, dsel_wdata, page_addr};
         assign dsel_q  = {1'b1, {PAGE_W{1'b0}}};
         assign reg_sel = 1'b0;
      end
   endgenerate

   assign dev_sel = pin_sel | reg_sel;

endmodule

// File: rtl/cam_match_hold.sv
module cam_match_hold #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_go,
   input  logic              dev_sel,
   input  logic              loc_hit,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic              loc_multi,
   output logic              hit_q,
   output logic              multi_q,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q   <= 1'b0;
         multi_q <= 1'b0;
         addr_q  <= '0;
      end else if (cmp_go) begin
         if (dev_sel) begin
            hit_q   <= loc_hit;
            multi_q <= loc_hit & loc_multi;
            addr_q  <= loc_addr;
         end else begin
            // sitting out a compare drops whatever was held
            hit_q   <= 1'b0;
            multi_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cam_bus_drive.sv
module cam_bus_drive
   import cam_cascade_pkg::*;
(
   input  logic      oe_n,
   input  logic      prio_in,
   input  logic      last_dev,
   input  logic      hit_q,
   output logic      prio_out,
   output drv_mode_e mode
);

   assign prio_out = prio_in | hit_q;

   always_comb begin
      mode = DRV_OFF;
      if (!oe_n && !prio_in) begin
         if (hit_q) begin
            mode = DRV_HIT;
         end else if (last_dev) begin
            mode = DRV_ONES;
         end
      end
   end

endmodule

// File: rtl/cam_prio_cascade.sv
module cam_prio_cascade
   import cam_cascade_pkg::*;
#(
   parameter int PAGE_W       = 4,
   parameter int ADDR_W       = 12,
   parameter bit USE_DSEL_REG = 1'b1,
   localparam int RES_W       = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] page_addr,
   input  logic              last_dev,
   input  logic              cs_a_n,
   input  logic              cs_b_n,
   input  logic              dsel_we,
   input  logic [PAGE_W:0]   dsel_wdata,
   input  logic              cmp_go,
   input  logic              loc_hit,
   input  logic [ADDR_W-1:0] loc_addr,
   input  logic              loc_multi,
   input  logic              prio_in,
   input  logic              oe_n,
   output logic              prio_out,
   output logic              match_out,
   output logic              multi_out,
   output logic [RES_W-1:0]  res_data,
   output logic              res_oe
);

   generate
      if (PAGE_W < 1 || PAGE_W > 16) begin : g_bad_page_w
         $error("cam_prio_cascade: PAGE_W must lie in 1..16");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("cam_prio_cascade: ADDR_W must lie in 1..32");
      end
   endgenerate

   logic              dev_sel;
   logic [PAGE_W:0]   dsel_q;
   logic [ADDR_W-1:0] addr_q;
   drv_mode_e         mode;

   cam_dev_select #(
      .PAGE_W      (PAGE_W),
      .USE_DSEL_REG(USE_DSEL_REG)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .page_addr (page_addr),
      .cs_a_n    (cs_a_n),
      .cs_b_n    (cs_b_n),
      .dsel_we   (dsel_we),
      .dsel_wdata(dsel_wdata),
      .dev_sel   (dev_sel),
      .dsel_q    (dsel_q)
   );

   cam_match_hold #(
      .ADDR_W(ADDR_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_go   (cmp_go),
      .dev_sel  (dev_sel),
      .loc_hit  (loc_hit),
      .loc_addr (loc_addr),
      .loc_multi(loc_multi),
      .hit_q    (match_out),
      .multi_q  (multi_out),
      .addr_q   (addr_q)
   );

   cam_bus_drive u_drv (
      .oe_n    (oe_n),
      .prio_in (prio_in),
      .last_dev(last_dev),
      .hit_q   (match_out),
      .prio_out(prio_out),
      .mode    (mode)
   );

   always_comb begin
      unique case (mode)
         DRV_HIT:  res_data = {page_addr, addr_q};
         DRV_ONES: res_data = '1;
         default:  res_data = '0;
      endcase
   end

   assign res_oe = (mode != DRV_OFF);

endmodule

// File: rtl/cam_prio_cascade_chk.sv
module cam_prio_cascade_chk #(
   parameter int PAGE_W = 4,
   parameter int ADDR_W = 12,
   localparam int RES_W = PAGE_W + ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PAGE_W-1:0] page_addr,
   input logic              last_dev,
   input logic              cs_a_n,
   input logic              cs_b_n,
   input logic              cmp_go,
   input logic              dev_sel,
   input logic [PAGE_W:0]   dsel_q,
   input logic              prio_in,
   input logic              oe_n,
   input logic              prio_out,
   input logic              match_out,
   input logic              multi_out,
   input logic [RES_W-1:0]  res_data,
   input logic              res_oe
);

   assert_pin_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_a_n || !cs_b_n) |-> dev_sel);

   assert_reg_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsel_q[PAGE_W] && dsel_q[PAGE_W-1:0] == page_addr) |-> dev_sel);

   assert_unsel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go && !dev_sel) |=> (!match_out && !multi_out));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_go |=> ($stable(match_out) && $stable(multi_out)));

   assert_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_out || prio_in) |-> prio_out);

   assert_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && !prio_in && match_out) |->
         (res_oe && res_data[RES_W-1 -: PAGE_W] == page_addr));

   assert_lower_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_in || oe_n) |-> !res_oe);

   assert_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_oe && !match_out) |-> (last_dev && res_data == '1));

   assert_multi_implies_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      multi_out |-> match_out);

endmodule

bind cam_prio_cascade cam_prio_cascade_chk #(
   .PAGE_W(PAGE_W),
   .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/cam_prio_cascade_test.sv
`timescale 1ns/1ps
module cam_prio_cascade_test;

   localparam int N  = 4;
   localparam int PW = 4;
   localparam int AW = 12;
   localparam int RW = PW + AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          cmp_go;
   logic [N-1:0]  cs_a_n, cs_b_n, dsel_we, loc_hit, loc_multi, oe_n;
   logic [N-1:0]  prio_in, prio_out, match_out, multi_out, res_oe;
   logic [PW:0]   dsel_wdata [N];
   logic [AW-1:0] loc_addr   [N];
   logic [RW-1:0] res_data   [N];

   int checks = 0;
   int fails  = 0;

   function automatic logic [PW-1:0] page_of(int i);
      return PW'(i * 3 + 2);
   endfunction

   generate
      for (genvar g = 0; g < N; g++) begin : dev
         localparam logic [PW-1:0] PG = PW'(g * 3 + 2);
         if (g == 0) begin : g_top
            assign prio_in[g] = 1'b0;
         end else begin : g_rest
            assign prio_in[g] = prio_out[g-1];
         end
         cam_prio_cascade #(.PAGE_W(PW), .ADDR_W(AW)) uut (
            .clk       (clk),
            .rst_n     (rst_n),
            .page_addr (PG),
            .last_dev  (g == N - 1),
            .cs_a_n    (cs_a_n[g]),
            .cs_b_n    (cs_b_n[g]),
            .dsel_we   (dsel_we[g]),
            .dsel_wdata(dsel_wdata[g]),
            .cmp_go    (cmp_go),
            .loc_hit   (loc_hit[g]),
            .loc_addr  (loc_addr[g]),
            .loc_multi (loc_multi[g]),
            .prio_in   (prio_in[g]),
            .oe_n      (oe_n[g]),
            .prio_out  (prio_out[g]),
            .match_out (match_out[g]),
            .multi_out (multi_out[g]),
            .res_data  (res_data[g]),
            .res_oe    (res_oe[g])
         );
      end
   endgenerate

   // bench model
   logic [N-1:0]  m_hit, m_multi;
   logic [AW-1:0] m_addr [N];
   logic [PW:0]   m_dsel [N];

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_hit = '0;
      m_multi = '0;
      for (int i = 0; i < N; i++) begin
         m_addr[i] = '0;
         m_dsel[i] = {1'b1, {PW{1'b0}}};
      end
   endtask

   task automatic model_edge();
      for (int i = 0; i < N; i++) begin
         bit sel;
         sel = !cs_a_n[i] || !cs_b_n[i] ||
               (!m_dsel[i][PW] && m_dsel[i][PW-1:0] == page_of(i));
         if (cmp_go) begin
            m_hit[i]   = sel && loc_hit[i];
            m_multi[i] = sel && loc_hit[i] && loc_multi[i];
            if (sel) m_addr[i] = loc_addr[i];
         end
         if (dsel_we[i]) m_dsel[i] = dsel_wdata[i];
      end
   endtask

   task automatic check_all(string req);
      int          exp_cnt;
      logic [RW-1:0] exp_val, act_val;
      int          first;
      first = -1;
      for (int i = N - 1; i >= 0; i--) if (m_hit[i]) first = i;
      exp_cnt = 0;
      exp_val = '0;
      if (first >= 0) begin
         if (!oe_n[first]) begin
            exp_cnt = 1;
            exp_val = {page_of(first), m_addr[first]};
         end
      end else if (!oe_n[N-1]) begin
         exp_cnt = 1;
         exp_val = '1;
      end
      act_val = '0;
      for (int i = 0; i < N; i++) if (res_oe[i]) act_val = act_val | res_data[i];
      chk(match_out == m_hit, {req, " match_out"}, 32'(match_out), 32'(m_hit));
      chk(multi_out == m_multi, {req, " multi_out"}, 32'(multi_out), 32'(m_multi));
      chk($countones(res_oe) == exp_cnt, {req, " driver count R7"},
          32'($countones(res_oe)), 32'(exp_cnt));
      if (exp_cnt == 1)
         chk(act_val == exp_val, {req, " bus word R6/R8"}, 32'(act_val), 32'(exp_val));
      chk(prio_out[N-1] == |m_hit, {req, " chain end R5"}, 32'(prio_out[N-1]), 32'(|m_hit));
   endtask

   task automatic idle();
      cmp_go  = 1'b0;
      cs_a_n  = '1;
      cs_b_n  = '1;
      dsel_we = '0;
      loc_hit = '0;
      loc_multi = '0;
      oe_n    = '0;
      for (int i = 0; i < N; i++) begin
         dsel_wdata[i] = '0;
         loc_addr[i]   = AW'(16'h100 * (i + 1) + i);
      end
   endtask

   // called at a falling edge with inputs already set
   task automatic step(string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(req);
      idle();
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      oe_n  = '1;
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state, all enables off -> nothing drives
      check_all("R9");
      // R8: no match anywhere, enables on -> last device drives ones
      oe_n = '0;
      #1 check_all("R8");
      chk(res_oe == 4'b1000, "R8 ones owner", 32'(res_oe), 32'h8);

      // R1: chip select A on device 2 only
      @(negedge clk);
      cmp_go = 1'b1; loc_hit = '1; cs_a_n[2] = 1'b0;
      step("R1");
      chk(match_out == 4'b0100, "R1 cs_a", 32'(match_out), 32'h4);
      // R1: chip select B on device 1 only
      cmp_go = 1'b1; loc_hit = '1; cs_b_n[1] = 1'b0; loc_multi[1] = 1'b1;
      step("R1");
      chk(multi_out == 4'b0010, "R1/R3 multi", 32'(multi_out), 32'h2);

      // R2: select register, enabled with matching page, device 3
      dsel_we[3] = 1'b1; dsel_wdata[3] = {1'b0, page_of(3)};
      step("R2");
      cmp_go = 1'b1; loc_hit = '1;
      step("R2");
      chk(match_out == 4'b1000, "R2 reg select", 32'(match_out), 32'h8);
      // R2: enable bit high -> not selected
      dsel_we[3] = 1'b1; dsel_wdata[3] = {1'b1, page_of(3)};
      step("R2");
      cmp_go = 1'b1; loc_hit = '1;
      step("R2");
      chk(match_out == 4'b0000, "R2 disabled reg", 32'(match_out), 32'h0);
      // R2: wrong page value -> not selected
      dsel_we[0] = 1'b1; dsel_wdata[0] = {1'b0, page_of(1)};
      step("R2");
      cmp_go = 1'b1; loc_hit = '1;
      step("R2");
      chk(match_out == 4'b0000, "R2 page mismatch", 32'(match_out), 32'h0);

      // R4: hits held while no compare occurs
      cmp_go = 1'b1; loc_hit = 4'b0101; cs_a_n = '0;
      step("R4");
      loc_hit = '0; cs_a_n = '0; loc_multi = '1;
      step("R4");
      chk(match_out == 4'b0101, "R4 hold", 32'(match_out), 32'h5);

      // R7: owner disabled, lower matching device must stay off
      oe_n = 4'b0001;
      #1 check_all("R7");
      chk(res_oe == 4'b0000, "R7 lower quiet", 32'(res_oe), 32'h0);
      oe_n = '0;

      // R3: stale clear, device 0 sits out, device 2 selected without hit
      @(negedge clk);
      cmp_go = 1'b1; cs_b_n[2] = 1'b0; loc_hit = '1; loc_hit[2] = 1'b0;
      step("R3");
      chk(match_out == 4'b0000, "R3 stale clear", 32'(match_out), 32'h0);

      // R6: two hits, upper wins
      cmp_go = 1'b1; cs_a_n = '0; loc_hit = 4'b1010;
      step("R6");

      // constrained random mix
      for (int s = 0; s < 600; s++) begin
         cmp_go = ($urandom % 2) == 0;
         for (int i = 0; i < N; i++) begin
            cs_a_n[i]    = ($urandom % 4) != 0;
            cs_b_n[i]    = ($urandom % 5) != 0;
            loc_hit[i]   = ($urandom % 3) == 0;
            loc_multi[i] = $urandom % 2;
            loc_addr[i]  = AW'($urandom);
            oe_n[i]      = ($urandom % 8) == 0;
            dsel_we[i]   = ($urandom % 8) == 0;
            dsel_wdata[i] = {1'($urandom % 2),
                             (($urandom % 2) == 0) ? page_of(i) : PW'($urandom)};
         end
         step("RAND R1 R2 R3 R4 R5 R6 R7 R8");
      end

      finish_run();
   end

endmodule